// File: doc/BRIEF.md
# Circuit Setup Source Controller

This block sits on the network side of a source endpoint in a circuit-switched mesh. It runs one transaction at a time. A local requester hands it an 8-bit destination, given as two 4-bit mesh coordinates, together with a payload length in words. The block frames a one-word routing request onto the 16-bit forward bus and watches the 2-bit reverse control lines for the reply.

A refusal from the network starts a fixed back-off. After the back-off the identical request goes out again. An acceptance opens the circuit, and the block then passes exactly the latched number of payload words from the local data handshake onto the forward bus. After the last word it frames a single teardown word that frees the route, and it pulses `done`. A saturating counter reports how many refusals the current transaction has met.

Top module: `circ_setup_src`

## Requirements
- R1: After reset `fwd_frame`, `dat_ready` and `done` are low, `req_ready` is high and `retry_cnt` is zero.
- R2: When `req_valid` and `req_ready` are both high at a clock edge, the next cycle carries exactly one framed request word {2'b01, 2'b00, len[3:0], dest[7:0]}. `req_ready` stays low until the transaction ends.
- R3: While the block waits for a reply, no payload is accepted (`dat_ready` low). A reverse code of 01 (acknowledge) seen in that state opens the payload phase on the next cycle.
- R4: A reverse code of 10 (negative acknowledge) seen while waiting is followed by BACKOFF idle cycles with the frame low. The request word is then sent again unchanged.
- R5: `retry_cnt` clears when a request is accepted, rises by one on each negative acknowledge, and saturates at its maximum.
- R6: In the payload phase `dat_ready` is high, and every cycle with `dat_valid` high drives `dat_word` onto `fwd_data` with the frame high. The frame is low in cycles without `dat_valid`. Exactly `len` words are passed.
- R7: The cycle after the last payload word is accepted, or the cycle after the acknowledge when `len` is zero, carries one framed teardown word 16'hC000.
- R8: `done` is high for exactly one cycle, the cycle after the teardown word. `req_ready` is high again in that same cycle.
- R9: Reverse codes 00 and 11 are ignored while waiting. Every reverse code is ignored outside the waiting state.
- R10: The frame is low while the block is idle, waiting or backing off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Network clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local transaction request |
| req_ready | output | 1 | Block idle, request can be taken |
| req_dest | input | 8 | Destination, high nibble and low nibble are the coordinates |
| req_len | input | 4 | Payload length in words |
| dat_valid | input | 1 | Payload word offered |
| dat_ready | output | 1 | Payload word accepted this cycle |
| dat_word | input | 16 | Payload word |
| fwd_data | output | 16 | Forward data bus |
| fwd_frame | output | 1 | Forward framing bit |
| rev_ctrl | input | 2 | Reverse control from the network |
| done | output | 1 | Teardown completed pulse |
| retry_cnt | output | 4 | Negative acknowledges in the current transaction |

## Verification
The inline assertions check several rules on every cycle. `done` is a single-cycle pulse that follows the teardown. The payload phase is entered only from an acknowledge. The frame goes quiet after a refusal. A request is framed the cycle after it is accepted. The retry count moves only by clearing or by single increments. The remaining-word count is never zero while payload is still expected.

Only the bench scenarios can show three further things. The first is the exact back-off length before a resend. The second is the word-by-word payload contents and count. The third is that reserved and out-of-phase reverse codes leave the transaction undisturbed. The bench also covers the zero-length payload and saturation of the retry counter.

// File: rtl/circ_setup_src.sv
module circ_setup_src #(
  parameter int DW      = 16,
  parameter int AW      = 8,
  parameter int LW      = 4,
  parameter int BACKOFF = 8,
  parameter int RW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_dest,
  input  logic [LW-1:0] req_len,
  input  logic          dat_valid,
  output logic          dat_ready,
  input  logic [DW-1:0] dat_word,
  output logic [DW-1:0] fwd_data,
  output logic          fwd_frame,
  input  logic [1:0]    rev_ctrl,
  output logic          done,
  output logic [RW-1:0] retry_cnt
);

  localparam int BOW = $clog2(BACKOFF + 1);
  localparam int PAD = DW - 2 - LW - AW;
  localparam logic [1:0] REV_ACK  = 2'b01;
  localparam logic [1:0] REV_NACK = 2'b10;
  localparam logic [DW-1:0] TEAR_WORD = {2'b11, {(DW-2){1'b0}}};

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_BACK, S_XFER, S_TEAR} st_t;

  st_t            st;
  logic [AW-1:0]  dest_q;
  logic [LW-1:0]  len_q;
  logic [LW-1:0]  left_q;
  logic [BOW-1:0] bo_q;

  wire            take     = req_valid && req_ready;
  wire [DW-1:0]   req_word = {2'b01, {PAD{1'b0}}, len_q, dest_q};

  assign req_ready = (st == S_IDLE);
  assign dat_ready = (st == S_XFER);
  assign fwd_frame = (st == S_REQ) || (st == S_TEAR) || (st == S_XFER && dat_valid);
  assign fwd_data  = (st == S_REQ)  ? req_word  :
                     (st == S_TEAR) ? TEAR_WORD :
                     (st == S_XFER && dat_valid) ? dat_word : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      dest_q    <= '0;
      len_q     <= '0;
      left_q    <= '0;
      bo_q      <= '0;
      retry_cnt <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          dest_q    <= req_dest;
          len_q     <= req_len;
          retry_cnt <= '0;
          st        <= S_REQ;
        end
        S_REQ: st <= S_WAIT;
        S_WAIT: begin
          if (rev_ctrl == REV_ACK) begin
            left_q <= len_q;
            st     <= (len_q == '0) ? S_TEAR : S_XFER;
          end else if (rev_ctrl == REV_NACK) begin
            bo_q <= BOW'(BACKOFF - 1);
            if (retry_cnt != '1) retry_cnt <= retry_cnt + 1'b1;
            st <= S_BACK;
          end
        end
        S_BACK: begin
          if (bo_q == '0) st <= S_REQ;
          else bo_q <= bo_q - 1'b1;
        end
        S_XFER: if (dat_valid) begin
          left_q <= left_q - 1'b1;
          if (left_q == LW'(1)) st <= S_TEAR;
        end
        S_TEAR: begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_tear_then_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TEAR) |=> (done && req_ready));
  assert_xfer_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dat_ready) |-> ($past(rev_ctrl) == REV_ACK));
  assert_quiet_after_nack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && rev_ctrl == REV_NACK) |=> (!fwd_frame && !dat_ready));
  assert_retry_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(retry_cnt) |-> (retry_cnt == '0 || retry_cnt == $past(retry_cnt) + 1'b1));
  assert_req_framed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (fwd_frame && fwd_data[DW-1 -: 2] == 2'b01 && !req_ready));
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dat_ready |-> (left_q != '0));

endmodule

// File: tb/circ_setup_src_tb.sv
module circ_setup_src_tb;
  localparam int BO = 8;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [7:0]  req_dest = 0;
  logic [3:0]  req_len = 0;
  logic        dat_valid = 0;
  logic        dat_ready;
  logic [15:0] dat_word = 0;
  logic [15:0] fwd_data;
  logic        fwd_frame;
  logic [1:0]  rev_ctrl = 0;
  logic        done;
  logic [3:0]  retry_cnt;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  circ_setup_src #(.BACKOFF(BO)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dest(req_dest), .req_len(req_len), .dat_valid(dat_valid),
    .dat_ready(dat_ready), .dat_word(dat_word), .fwd_data(fwd_data),
    .fwd_frame(fwd_frame), .rev_ctrl(rev_ctrl), .done(done), .retry_cnt(retry_cnt)
  );

  // {dest, len, nacks}
  localparam logic [15:0] VEC [6] = '{
    {8'h23, 4'd3,  4'd0}, {8'h00, 4'd1, 4'd1}, {8'hFF, 4'd15, 4'd2},
    {8'h5A, 4'd4,  4'd3}, {8'h31, 4'd2, 4'd1}, {8'h7E, 4'd8,  4'd0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_txn(input logic [7:0] d, input logic [3:0] l, input int nacks, input bit noise);
    logic [15:0] rw;
    int k;
    rw = {2'b01, 2'b00, l, d};
    req_valid = 1; req_dest = d; req_len = l;
    cyc();
    req_valid = 0;
    chk(fwd_frame && fwd_data == rw, "R2 request word", fwd_data, rw);
    chk(!req_ready, "R2 busy", req_ready, 0);
    chk(retry_cnt == 0, "R5 cleared on accept", retry_cnt, 0);
    for (int n = 0; n < nacks; n++) begin
      cyc();
      chk(!fwd_frame && !dat_ready, "R10/R3 quiet in wait", fwd_frame, 0);
      rev_ctrl = 2'b10;
      cyc();
      rev_ctrl = 2'b00;
      k = 1;
      while (!fwd_frame && k < 60) begin
        cyc();
        k++;
      end
      chk(k == BO + 1, "R4 back-off length", k, BO + 1);
      chk(fwd_frame && fwd_data == rw, "R4 resend same word", fwd_data, rw);
    end
    cyc();
    if (noise) begin
      rev_ctrl = 2'b11;
      cyc();
      cyc();
      rev_ctrl = 2'b00;
      cyc();
      chk(!fwd_frame && !dat_ready && !req_ready, "R9 reserved codes ignored", dat_ready, 0);
    end
    chk(!dat_ready, "R3 no payload before ack", dat_ready, 0);
    rev_ctrl = 2'b01;
    cyc();
    rev_ctrl = noise ? 2'b10 : 2'b00;
    for (int i = 0; i < l; i++) begin
      chk(dat_ready, "R6 ready in payload", dat_ready, 1);
      if (i % 2 == 1) begin
        dat_valid = 0;
        #1;
        chk(!fwd_frame, "R6 frame low in gap", fwd_frame, 0);
        cyc();
      end
      dat_valid = 1;
      dat_word = {d, 4'(i), l};
      #1;
      chk(fwd_frame && fwd_data == {d, 4'(i), l}, "R6 payload word", fwd_data, {d, 4'(i), l});
      cyc();
      dat_valid = 0;
    end
    chk(retry_cnt == 4'(nacks > 15 ? 15 : nacks), "R5 retry count", retry_cnt, (nacks > 15 ? 15 : nacks));
    chk(fwd_frame && fwd_data == 16'hC000, "R7 teardown word", fwd_data, 16'hC000);
    chk(!dat_ready, "R6 exact length", dat_ready, 0);
    rev_ctrl = 2'b00;
    cyc();
    chk(done && req_ready && !fwd_frame, "R8 done after teardown", done, 1);
    cyc();
    chk(!done, "R8 done one cycle", done, 0);
  endtask

  initial begin
    repeat (3) cyc();
    chk(!fwd_frame && !dat_ready && !done && req_ready && retry_cnt == 0, "R1 reset state",
        {fwd_frame, dat_ready, done, req_ready}, 4'b0001);
    rst_n = 1;
    cyc();
    chk(!fwd_frame && req_ready, "R10 idle frame low", fwd_frame, 0);
    foreach (VEC[v]) run_txn(VEC[v][15:8], VEC[v][7:4], int'(VEC[v][3:0]), 1'b0);
    run_txn(8'h42, 4'd3, 1, 1'b1);
    run_txn(8'h11, 4'd0, 0, 1'b0);
    run_txn(8'hA5, 4'd1, 17, 1'b0);
    rst_n = 0;
    cyc();
    chk(req_ready && retry_cnt == 0, "R1 reset again", retry_cnt, 0);
    finished = 1;
  end

  initial begin
    int w;
    w = 0;
    while (!finished && w < 200000) begin
      @(posedge clk);
      w++;
    end
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", w);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule